// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a 64x64 pointer image on top of a raster pixel stream. The pointer image lives in a small internal byte memory at two bits per pixel and is filled through a byte-wide write port. Each two-bit code picks one of four outcomes for the screen pixel underneath it: the first cursor colour, the second cursor colour, the untouched screen pixel, or the bitwise complement of the screen pixel.

The display pipeline presents the current raster column and row together with the pixel it would otherwise show. One clock later the block returns the pixel to display. A register port sets the two colours, the screen position of the cursor, a pair of preset offsets and an enable bit. The presets hide a number of leading rows and columns of the image, so that a pointer can be clipped at the top or left edge of the screen while its position stays non-negative. Register writes land in a shadow copy that is moved into use only on a frame-start pulse, so a frame never shows a half-updated cursor.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_out` is zero and the cursor is disabled, so that every later pixel passes through until a frame start loads an enabled setting.
- R2: While the live enable bit (bit 7 of the control register, `reg_sel` 0) is clear, `pix_out` equals the `pix_in` that was presented one clock earlier.
- R3: Pixel code 2'b00 outputs colour 0 (register `reg_sel` 1, low `PIX_W` bits) and code 2'b01 outputs colour 1 (`reg_sel` 2, low `PIX_W` bits).
- R4: Pixel code 2'b10 outputs `pix_in` unchanged and code 2'b11 outputs its bitwise inverse.
- R5: Image pixel (col,row) is taken from bitmap byte address row*16 + col/4, bits 2*(col%4)+1 : 2*(col%4), so the lowest bit pair of a byte holds the leftmost of its four pixels.
- R6: The position register (`reg_sel` 3) holds y in bits 31:16 and x in bits 15:0; with zero presets, image pixel (col,row) is shown at screen point (x+col, y+row).
- R7: The preset register (`reg_sel` 4) holds a vertical skip in bits 31:16 and a horizontal skip in bits 15:0; image pixel (col,row) with col >= hskip and row >= vskip appears at (x+col-hskip, y+row-vskip), and every screen point that maps to no image pixel below 64 passes `pix_in` through.
- R8: Register writes have no visible effect until a `frame_start` pulse; the settings in use change only on the clock edge where `frame_start` is high.
- R9: A write through the bitmap port is used for pixels presented from the next clock on, without waiting for a frame start.
- R10: The output is registered: the result for the raster inputs presented in one cycle appears on `pix_out` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 colour 0, 2 colour 1, 3 position, 4 presets |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Pulse that moves the shadow registers into use |
| bmp_wr | input | 1 | Bitmap byte write strobe |
| bmp_addr | input | 10 | Bitmap byte address (row*16 + col/4) |
| bmp_wdata | input | 8 | Bitmap byte data, four pixel codes |
| raster_x | input | 16 | Current screen column |
| raster_y | input | 16 | Current screen row |
| pix_in | input | PIX_W | Screen pixel under the raster position |
| pix_out | output | PIX_W | Pixel to display, one clock later |

## Verification
The bench builds the block with its default 24-bit pixel, which keeps the colour and inversion results wide enough that a wrong selection almost never collides with the right one. The 64x64 image and 16-bit coordinates are fixed by the register format, so the bench reaches both clipping edges, the far image edge at column and row 63, and points just outside it on every side, by placing the cursor and presets near the origin as well as mid-screen.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int CUR_DIM       = 64;
    localparam int PIX_PER_BYTE  = 4;
    localparam int BYTES_PER_ROW = CUR_DIM / PIX_PER_BYTE;
    localparam int BMP_BYTES     = CUR_DIM * BYTES_PER_ROW;
    localparam int BMP_AW        = $clog2(BMP_BYTES);
    localparam int IDX_W         = $clog2(CUR_DIM);
    localparam int SUB_W         = $clog2(PIX_PER_BYTE);
    localparam int COORD_W       = 16;
    localparam int SEL_W         = 3;
    localparam int ENABLE_BIT    = 7;

    typedef enum logic [1:0] {
        CODE_COL0   = 2'b00,
        CODE_COL1   = 2'b01,
        CODE_CLEAR  = 2'b10,
        CODE_INVERT = 2'b11
    } cur_code_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_COL0   = 3'd1,
        SEL_COL1   = 3'd2,
        SEL_POS    = 3'd3,
        SEL_PRESET = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [COORD_W-1:0] pos_y;
        logic [COORD_W-1:0] pos_x;
        logic [COORD_W-1:0] skip_y;
        logic [COORD_W-1:0] skip_x;
    } cur_geom_t;

    // Picks the two-bit code of one pixel out of a packed byte.
    function automatic cur_code_e pick_code(input logic [7:0] b, input logic [SUB_W-1:0] sub);
        return cur_code_e'(b[{sub, 1'b0} +: 2]);
    endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             frame_start,
    output logic             live_en,
    output logic [PIX_W-1:0] live_col0,
    output logic [PIX_W-1:0] live_col1,
    output cur_geom_t        live_geom
);

    logic             sh_en;
    logic [PIX_W-1:0] sh_col0, sh_col1;
    cur_geom_t        sh_geom;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_en   <= 1'b0;
            sh_col0 <= '0;
            sh_col1 <= '0;
            sh_geom <= '0;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL:   sh_en   <= reg_wdata[ENABLE_BIT];
                SEL_COL0:   sh_col0 <= reg_wdata[PIX_W-1:0];
                SEL_COL1:   sh_col1 <= reg_wdata[PIX_W-1:0];
                SEL_POS: begin
                    sh_geom.pos_y <= reg_wdata[31:16];
                    sh_geom.pos_x <= reg_wdata[15:0];
                end
                SEL_PRESET: begin
                    sh_geom.skip_y <= reg_wdata[31:16];
                    sh_geom.skip_x <= reg_wdata[15:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_en   <= 1'b0;
            live_col0 <= '0;
            live_col1 <= '0;
            live_geom <= '0;
        end else if (frame_start) begin
            live_en   <= sh_en;
            live_col0 <= sh_col0;
            live_col1 <= sh_col1;
            live_geom <= sh_geom;
        end
    end

    // R8: settings in use never move between frame starts
    a_r8_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(live_geom) && $stable(live_en)
                          && $stable(live_col0) && $stable(live_col1)));

    // R1: reset leaves the cursor off until a frame start
    a_r1_off_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !live_en);

endmodule

// File: rtl/cursor_bitmap.sv
module cursor_bitmap
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BMP_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [BMP_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [BMP_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               live_en,
    input  logic [PIX_W-1:0]   live_col0,
    input  logic [PIX_W-1:0]   live_col1,
    input  cur_geom_t          live_geom,
    input  logic [COORD_W-1:0] raster_x,
    input  logic [COORD_W-1:0] raster_y,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [BMP_AW-1:0]  bmp_rd_addr,
    input  logic [7:0]         bmp_rd_data,
    output logic [PIX_W-1:0]   pix_out
);

    localparam int SPAN_W = COORD_W + 1;

    logic [SPAN_W-1:0] col_w, row_w;
    logic              in_x, in_y, hit;
    logic [IDX_W-1:0]  col, row;
    cur_code_e         code;

    always_comb begin
        col_w = {1'b0, raster_x} - {1'b0, live_geom.pos_x} + {1'b0, live_geom.skip_x};
        row_w = {1'b0, raster_y} - {1'b0, live_geom.pos_y} + {1'b0, live_geom.skip_y};
        in_x  = (raster_x >= live_geom.pos_x) && (col_w < SPAN_W'(CUR_DIM));
        in_y  = (raster_y >= live_geom.pos_y) && (row_w < SPAN_W'(CUR_DIM));
        hit   = in_x && in_y;
        col   = col_w[IDX_W-1:0];
        row   = row_w[IDX_W-1:0];
        bmp_rd_addr = {row, col[IDX_W-1:SUB_W]};
        code  = pick_code(bmp_rd_data, col[SUB_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else if (!live_en || !hit) begin
            pix_out <= pix_in;
        end else begin
            case (code)
                CODE_COL0:   pix_out <= live_col0;
                CODE_COL1:   pix_out <= live_col1;
                CODE_CLEAR:  pix_out <= pix_in;
                CODE_INVERT: pix_out <= ~pix_in;
                default:     pix_out <= pix_in;
            endcase
        end
    end

    // R2: disabled cursor is a one-cycle wire
    a_r2_disabled_passes: assert property (@(posedge clk) disable iff (rst)
        !live_en |=> pix_out == $past(pix_in));

    // R7: a point outside the visible image is untouched
    a_r7_outside_passes: assert property (@(posedge clk) disable iff (rst)
        (live_en && !hit) |=> pix_out == $past(pix_in));

    // R4: complement code yields the inverted screen pixel
    a_r4_invert: assert property (@(posedge clk) disable iff (rst)
        (live_en && hit && code == CODE_INVERT) |=> pix_out == ~$past(pix_in));

    // R3: colour codes never leak the screen pixel unless it equals the colour
    a_r3_colour0: assert property (@(posedge clk) disable iff (rst)
        (live_en && hit && code == CODE_COL0) |=> pix_out == $past(live_col0));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [31:0]        reg_wdata,
    input  logic               frame_start,
    input  logic               bmp_wr,
    input  logic [BMP_AW-1:0]  bmp_addr,
    input  logic [7:0]         bmp_wdata,
    input  logic [COORD_W-1:0] raster_x,
    input  logic [COORD_W-1:0] raster_y,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [PIX_W-1:0]   pix_out
);

    logic              live_en;
    logic [PIX_W-1:0]  live_col0, live_col1;
    cur_geom_t         live_geom;
    logic [BMP_AW-1:0] rd_addr;
    logic [7:0]        rd_data;

    cursor_regs #(.PIX_W(PIX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .frame_start (frame_start),
        .live_en     (live_en),
        .live_col0   (live_col0),
        .live_col1   (live_col1),
        .live_geom   (live_geom)
    );

    cursor_bitmap u_bitmap (
        .clk     (clk),
        .wr_en   (bmp_wr),
        .wr_addr (bmp_addr),
        .wr_data (bmp_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cursor_mix #(.PIX_W(PIX_W)) u_mix (
        .clk         (clk),
        .rst         (rst),
        .live_en     (live_en),
        .live_col0   (live_col0),
        .live_col1   (live_col1),
        .live_geom   (live_geom),
        .raster_x    (raster_x),
        .raster_y    (raster_y),
        .pix_in      (pix_in),
        .bmp_rd_addr (rd_addr),
        .bmp_rd_data (rd_data),
        .pix_out     (pix_out)
    );

endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr;
    logic [2:0]    reg_sel;
    logic [31:0]   reg_wdata;
    logic          frame_start;
    logic          bmp_wr;
    logic [9:0]    bmp_addr;
    logic [7:0]    bmp_wdata;
    logic [15:0]   raster_x, raster_y;
    logic [PW-1:0] pix_in, pix_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the block's programmable state
    logic [7:0]    m_mem [1024];
    bit            sh_en, ac_en;
    logic [PW-1:0] sh_c0, sh_c1, ac_c0, ac_c1;
    int            sh_px, sh_py, sh_hx, sh_hy, ac_px, ac_py, ac_hx, ac_hy;

    cursor_overlay #(.PIX_W(PW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .bmp_wr(bmp_wr),
        .bmp_addr(bmp_addr), .bmp_wdata(bmp_wdata), .raster_x(raster_x),
        .raster_y(raster_y), .pix_in(pix_in), .pix_out(pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PW-1:0] expect_pix(int x, int y, logic [PW-1:0] p);
        int col, row;
        logic [1:0] code;
        col = x - ac_px + ac_hx;
        row = y - ac_py + ac_hy;
        if (!ac_en || x < ac_px || y < ac_py || col >= 64 || row >= 64) return p;
        code = 2'((m_mem[row*16 + col/4] >> (2*(col%4))) & 8'h3);
        case (code)
            2'b00: return ac_c0;
            2'b01: return ac_c1;
            2'b10: return p;
            default: return ~p;
        endcase
    endfunction

    task automatic reg_write(input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (sel)
            0: sh_en = d[7];
            1: sh_c0 = d[PW-1:0];
            2: sh_c1 = d[PW-1:0];
            3: begin sh_py = int'(d[31:16]); sh_px = int'(d[15:0]); end
            4: begin sh_hy = int'(d[31:16]); sh_hx = int'(d[15:0]); end
            default: ;
        endcase
    endtask

    task automatic new_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        ac_en = sh_en; ac_c0 = sh_c0; ac_c1 = sh_c1;
        ac_px = sh_px; ac_py = sh_py; ac_hx = sh_hx; ac_hy = sh_hy;
    endtask

    task automatic bmp_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bmp_wr = 1'b1; bmp_addr = 10'(a); bmp_wdata = d;
        @(negedge clk);
        bmp_wr = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic probe(input int x, input int y, input string tag);
        logic [PW-1:0] p, e;
        @(negedge clk);
        p = PW'($urandom);
        raster_x = 16'(x); raster_y = 16'(y); pix_in = p;
        e = expect_pix(x, y, p);
        @(negedge clk);
        checks++;
        if (pix_out !== e) begin
            failures++;
            $display("FAIL %s at (%0d,%0d): actual %h expected %h", tag, x, y, pix_out, e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; frame_start = 0;
        bmp_wr = 0; bmp_addr = 0; bmp_wdata = 0; raster_x = 0; raster_y = 0; pix_in = 0;
        sh_en = 0; sh_c0 = 0; sh_c1 = 0; sh_px = 0; sh_py = 0; sh_hx = 0; sh_hy = 0;
        ac_en = 0; ac_c0 = 0; ac_c1 = 0; ac_px = 0; ac_py = 0; ac_hx = 0; ac_hy = 0;
        repeat (3) @(negedge clk);
        // R1: output cleared by reset
        checks++;
        if (pix_out !== '0) begin
            failures++;
            $display("FAIL R1 reset output: actual %h expected 0", pix_out);
        end
        rst = 1'b0;
        for (int a = 0; a < 1024; a++) bmp_write(a, 8'($urandom));

        // R1: after reset, cursor off even at origin
        probe(0, 0, "R1");
        // R2: settings loaded but enable clear
        reg_write(1, 32'h00123456);
        reg_write(2, 32'h00ABCDEF);
        reg_write(3, {16'd50, 16'd100});
        reg_write(4, 32'd0);
        new_frame();
        for (int i = 0; i < 4; i++) probe(100 + i, 50, "R2");

        // R3 R4 R5: byte row 2, byte 1 holds codes 0,1,2,3 for cols 4..7
        bmp_write(2*16 + 1, 8'b11_10_01_00);
        reg_write(0, 32'h80);
        // R8: enable not yet in use before the frame start
        probe(104, 52, "R8");
        new_frame();
        probe(104, 52, "R3");
        probe(105, 52, "R3");
        probe(106, 52, "R4");
        probe(107, 52, "R4");
        probe(104, 52, "R5");
        // R6: corners and just outside
        probe(100, 50, "R6");
        probe(163, 113, "R6");
        probe(164, 113, "R6");
        probe(163, 114, "R6");
        probe(99, 50, "R6");
        probe(100, 49, "R6");

        // R7: clip at top-left with presets
        reg_write(3, 32'd0);
        reg_write(4, {16'd2, 16'd3});
        new_frame();
        probe(0, 0, "R7");
        probe(60, 61, "R7");
        probe(61, 0, "R7");
        probe(0, 62, "R7");
        probe(1, 5, "R7");

        // R8: mid-frame move is not used until frame start
        reg_write(3, {16'd300, 16'd300});
        probe(1, 1, "R8");
        probe(300, 300, "R8");
        new_frame();
        probe(300, 300, "R8");
        probe(1, 1, "R8");

        // R9: bitmap write visible at once
        bmp_write(((300 - 300 + 2) * 16) + ((310 - 300 + 3) / 4), 8'hFF);
        probe(310, 300, "R9");
        bmp_write(((300 - 300 + 2) * 16) + ((310 - 300 + 3) / 4), 8'h00);
        probe(310, 300, "R9");

        // R10 and R6 R7: random placements and probes around the cursor
        for (int f = 0; f < 12; f++) begin
            reg_write(1, $urandom);
            reg_write(2, $urandom);
            reg_write(3, {16'(20 + $urandom_range(0, 400)), 16'(20 + $urandom_range(0, 400))});
            reg_write(4, {16'($urandom_range(0, 70)), 16'($urandom_range(0, 70))});
            reg_write(0, ($urandom_range(0, 5) == 0) ? 32'h0 : 32'h80);
            new_frame();
            for (int k = 0; k < 60; k++)
                probe(ac_px - 8 + $urandom_range(0, 80), ac_py - 8 + $urandom_range(0, 80), "R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule